// File: doc/BRIEF.md
# Oscillator Tuning Word Writer

This block sits between a frequency-control loop and the serial write engine of an external digitally controlled oscillator. The loop presents a signed tuning word for one cycle. The block screens it before anything reaches the bus. It refuses a word whose magnitude is larger than the oscillator accepts, and it refuses any write while a manual bit-level path owns the serial bus.

A word that passes both screens is held until the write engine reports idle. The block then places the device address and the word on the engine inputs and fires a one-cycle strobe. It waits for the transfer to finish and reads the engine's acknowledge result. Every accepted request ends in exactly one done pulse, which carries a 2-bit result code.

Top module: `osc_tune_writer`

## Requirements
- R1: A request whose word has an absolute value above LIMIT (default 8161512) ends with done and status 1 in the cycle after the request. No strobe is issued. The values +8161512 and -8161512 are accepted, and -2^31 is rejected.
- R2: A request made while `manual_en` is high ends with done and status 2 in the next cycle, with no strobe. When a word is both out of range and made while `manual_en` is high, status 1 takes precedence.
- R3: After a valid request is accepted, the block issues no strobe while `eng_busy` is high. The strobe comes one cycle after `eng_busy` is first seen low.
- R4: `eng_strobe` is high for exactly one cycle per write. During that cycle `eng_word` holds the request's word as a WORD_W-bit two's-complement pattern, and `eng_addr` holds the address given with the request.
- R5: The engine is taken to raise `eng_busy` from the cycle after the strobe until the transfer ends, with `eng_nack` valid once busy is low. The block raises done in the cycle after it first sees busy low following the strobe. Status is 3 if `eng_nack` was high at that point and 0 otherwise.
- R6: `done` is a single-cycle pulse, and each accepted request produces exactly one. The status codes are 0 ok, 1 range, 2 bus-owned and 3 nack.
- R7: A `req_valid` raised while an earlier request is still being handled is ignored. It produces no done and no strobe, and it does not change the word that is written.
- R8: While reset is asserted and after its release, `done` and `eng_strobe` are 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle request to write a tuning word |
| req_word | input | WORD_W | Signed tuning word |
| req_addr | input | ADDR_W | Device address for the write |
| manual_en | input | 1 | High while the manual bit-level path owns the bus |
| eng_busy | input | 1 | Write engine busy |
| eng_nack | input | 1 | Write engine acknowledge failure, valid when idle |
| eng_strobe | output | 1 | One-cycle launch of a write |
| eng_addr | output | ADDR_W | Address presented to the engine |
| eng_word | output | WORD_W | Tuning word presented to the engine |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Result code, valid with done |

## Verification
Two pairs of conditions can fall in the same cycle. In the first pair, a request carries an out-of-range word while `manual_en` is high; the bench drives both together and expects the range code, not the bus-owned code. In the second pair, a fresh `req_valid` arrives in the cycle the sequencer is waiting on the engine. The bench makes that second request out of range on purpose, so a wrongly accepted second request would show up as an extra done with status 1. The scoreboard judges this case by finding exactly one done and a strobe that carries the first word.

// File: rtl/osc_tune_pkg.sv
package osc_tune_pkg;

  typedef enum logic [1:0] {
    TS_OK    = 2'd0,
    TS_RANGE = 2'd1,
    TS_BUS   = 2'd2,
    TS_NACK  = 2'd3
  } tune_status_e;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WAIT,
    SQ_STROBE,
    SQ_RESP
  } seq_state_e;

  // magnitude of a sign-extended word; 64 bits hold |-2^(W-1)| for W <= 63
  function automatic logic [63:0] tune_mag(input logic signed [63:0] v);
    return (v < 0) ? 64'(-v) : 64'(v);
  endfunction

  function automatic logic tune_exceeds(input logic signed [63:0] v,
                                        input logic [63:0] limit);
    return tune_mag(v) > limit;
  endfunction

endpackage

// File: rtl/tune_range_check.sv
module tune_range_check #(
  parameter int WORD_W = 32,
  parameter int LIMIT  = 8161512
) (
  input  logic signed [WORD_W-1:0] word,
  output logic                     over
);
  import osc_tune_pkg::*;

  localparam logic [63:0] LIMIT_W = 64'(LIMIT);

  logic signed [63:0] word_ext;

  always_comb begin
    word_ext = 64'(word);
    over     = tune_exceeds(word_ext, LIMIT_W);
  end

endmodule

// File: rtl/tune_handshake_seq.sv
module tune_handshake_seq #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic signed [WORD_W-1:0] req_word,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     reject_range,
  input  logic                     manual_en,
  input  logic                     eng_busy,
  input  logic                     eng_nack,
  output logic                     eng_strobe,
  output logic [ADDR_W-1:0]        eng_addr,
  output logic signed [WORD_W-1:0] eng_word,
  output logic                     done,
  output logic [1:0]               status,
  output logic                     req_accept
);
  import osc_tune_pkg::*;

  seq_state_e                state_q;
  tune_status_e              status_q;
  logic                      done_q;
  logic signed [WORD_W-1:0]  hold_word_q;
  logic [ADDR_W-1:0]         hold_addr_q;
  logic signed [WORD_W-1:0]  out_word_q;
  logic [ADDR_W-1:0]         out_addr_q;

  assign req_accept = req_valid && (state_q == SQ_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SQ_IDLE;
      status_q    <= TS_OK;
      done_q      <= 1'b0;
      hold_word_q <= '0;
      hold_addr_q <= '0;
      out_word_q  <= '0;
      out_addr_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: begin
          if (req_accept) begin
            if (reject_range) begin
              done_q   <= 1'b1;
              status_q <= TS_RANGE;
            end else if (manual_en) begin
              done_q   <= 1'b1;
              status_q <= TS_BUS;
            end else begin
              hold_word_q <= req_word;
              hold_addr_q <= req_addr;
              state_q     <= SQ_WAIT;
            end
          end
        end
        SQ_WAIT: begin
          if (!eng_busy) begin
            out_word_q <= hold_word_q;
            out_addr_q <= hold_addr_q;
            state_q    <= SQ_STROBE;
          end
        end
        SQ_STROBE: state_q <= SQ_RESP;
        SQ_RESP: begin
          if (!eng_busy) begin
            done_q   <= 1'b1;
            status_q <= eng_nack ? TS_NACK : TS_OK;
            state_q  <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign eng_strobe = (state_q == SQ_STROBE);
  assign eng_word   = out_word_q;
  assign eng_addr   = out_addr_q;
  assign done       = done_q;
  assign status     = status_q;

endmodule

// File: rtl/osc_tune_writer.sv
module osc_tune_writer #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 7,
  parameter int LIMIT  = 8161512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic signed [WORD_W-1:0] req_word,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     manual_en,
  input  logic                     eng_busy,
  input  logic                     eng_nack,
  output logic                     eng_strobe,
  output logic [ADDR_W-1:0]        eng_addr,
  output logic signed [WORD_W-1:0] eng_word,
  output logic                     done,
  output logic [1:0]               status
);

  logic word_over;
  logic req_accept;

  tune_range_check #(.WORD_W(WORD_W), .LIMIT(LIMIT)) u_range (
    .word (req_word),
    .over (word_over)
  );

  tune_handshake_seq #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_word     (req_word),
    .req_addr     (req_addr),
    .reject_range (word_over),
    .manual_en    (manual_en),
    .eng_busy     (eng_busy),
    .eng_nack     (eng_nack),
    .eng_strobe   (eng_strobe),
    .eng_addr     (eng_addr),
    .eng_word     (eng_word),
    .done         (done),
    .status       (status),
    .req_accept   (req_accept)
  );

endmodule

// File: rtl/osc_tune_writer_chk.sv
module osc_tune_writer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_accept,
  input logic       word_over,
  input logic       manual_en,
  input logic       eng_busy,
  input logic       eng_nack,
  input logic       eng_strobe,
  input logic       done,
  input logic [1:0] status
);

  a_r1_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && word_over) |=> (done && status == 2'd1));

  a_r2_bus_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && !word_over && manual_en) |=> (done && status == 2'd2));

  a_r3_strobe_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_strobe |-> !$past(eng_busy));

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    eng_strobe |=> !eng_strobe);

  a_r5_nack_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd3) |-> ($past(eng_nack) && !$past(eng_busy)));

  a_r5_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd0) |-> (!$past(eng_nack) && !$past(eng_busy)));

  a_r8_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!done && !eng_strobe && status == 2'd0));

endmodule

bind osc_tune_writer osc_tune_writer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_accept (req_accept),
  .word_over  (word_over),
  .manual_en  (manual_en),
  .eng_busy   (eng_busy),
  .eng_nack   (eng_nack),
  .eng_strobe (eng_strobe),
  .done       (done),
  .status     (status)
);

// File: tb/osc_tune_writer_tb.sv
module osc_tune_writer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 32;
  localparam int ADDR_W     = 7;
  localparam longint LIMIT  = 8161512;
  localparam int ENG_LAT    = 5;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     req_valid = 1'b0;
  logic signed [WORD_W-1:0] req_word = '0;
  logic [ADDR_W-1:0]        req_addr = '0;
  logic                     manual_en = 1'b0;
  logic                     eng_busy;
  logic                     eng_nack;
  logic                     eng_strobe;
  logic [ADDR_W-1:0]        eng_addr;
  logic signed [WORD_W-1:0] eng_word;
  logic                     done;
  logic [1:0]               status;

  // engine model
  logic ext_busy = 1'b0;
  logic nack_plan = 1'b0;
  logic nack_q;
  int   eng_cnt;

  int checks = 0;
  int fails = 0;
  int done_seen = 0;
  int strobe_seen = 0;
  logic prev_busy = 1'b0;
  logic prev_done = 1'b0;
  bit   finished = 1'b0;

  typedef struct {
    logic [1:0] code;
    string      tag;
  } exp_res_t;

  typedef struct {
    logic signed [WORD_W-1:0] word;
    logic [ADDR_W-1:0]        addr;
  } exp_wr_t;

  exp_res_t res_q[$];
  exp_wr_t  wr_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      eng_cnt <= 0;
      nack_q  <= 1'b0;
    end else if (eng_strobe) begin
      eng_cnt <= ENG_LAT;
      nack_q  <= nack_plan;
    end else if (eng_cnt != 0) begin
      eng_cnt <= eng_cnt - 1;
    end
  end

  assign eng_busy = ext_busy || (eng_cnt != 0);
  assign eng_nack = nack_q;

  osc_tune_writer #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LIMIT(8161512)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_word   (req_word),
    .req_addr   (req_addr),
    .manual_en  (manual_en),
    .eng_busy   (eng_busy),
    .eng_nack   (eng_nack),
    .eng_strobe (eng_strobe),
    .eng_addr   (eng_addr),
    .eng_word   (eng_word),
    .done       (done),
    .status     (status)
  );

  // monitor: compares results against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (eng_strobe) begin
        strobe_seen++;
        checks++;
        if (wr_q.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected strobe word=%0d expected none", eng_word);
        end else begin
          exp_wr_t w;
          w = wr_q.pop_front();
          if (eng_word !== w.word || eng_addr !== w.addr) begin
            fails++;
            $display("FAIL R4: word=%0d addr=%0h expected word=%0d addr=%0h",
                     eng_word, eng_addr, w.word, w.addr);
          end
        end
        checks++;
        if (prev_busy) begin
          fails++;
          $display("FAIL R3: strobe after busy cycle, busy=1 expected 0");
        end
      end
      if (done) begin
        done_seen++;
        checks++;
        if (res_q.size() == 0) begin
          fails++;
          $display("FAIL R7: unexpected done status=%0d expected none", status);
        end else begin
          exp_res_t r;
          r = res_q.pop_front();
          if (status !== r.code) begin
            fails++;
            $display("FAIL %s: status=%0d expected %0d", r.tag, status, r.code);
          end
        end
        checks++;
        if (prev_done) begin
          fails++;
          $display("FAIL R6: done high=2 cycles expected 1");
        end
      end
    end
    prev_busy = eng_busy;
    prev_done = done;
  end

  task automatic send(input logic signed [WORD_W-1:0] w, input logic [ADDR_W-1:0] a,
                      input logic man, input logic nk, input int hold_busy,
                      input bit extra);
    longint wl;
    longint mag;
    exp_res_t r;
    int n0;
    int s0;
    wl  = longint'(w);
    mag = (wl < 0) ? -wl : wl;
    if (mag > LIMIT) begin
      r.code = 2'd1; r.tag = "R1";
    end else if (man) begin
      r.code = 2'd2; r.tag = "R2";
    end else begin
      r.code = nk ? 2'd3 : 2'd0; r.tag = "R5";
      wr_q.push_back('{word: w, addr: a});
    end
    res_q.push_back(r);
    n0 = done_seen;
    s0 = strobe_seen;
    @(negedge clk);
    if (hold_busy > 0) ext_busy = 1'b1;
    req_valid = 1'b1; req_word = w; req_addr = a; manual_en = man; nack_plan = nk;
    @(negedge clk);
    req_valid = 1'b0; manual_en = 1'b0;
    if (extra) begin
      // out-of-range word: would give a status 1 done if accepted (R7)
      req_valid = 1'b1; req_word = 32'sh7fffffff; req_addr = ~a;
      @(negedge clk);
      req_valid = 1'b0;
    end
    if (hold_busy > 0) begin
      repeat (hold_busy) @(negedge clk);
      checks++;
      if (strobe_seen != s0) begin
        fails++;
        $display("FAIL R3: strobes while busy=%0d expected 0", strobe_seen - s0);
      end
      ext_busy = 1'b0;
    end
    while (done_seen == n0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (done !== 1'b0 || eng_strobe !== 1'b0 || status !== 2'd0) begin
      fails++;
      $display("FAIL R8: done=%0b strobe=%0b status=%0d expected 0 0 0", done, eng_strobe, status);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (done !== 1'b0 || eng_strobe !== 1'b0 || status !== 2'd0) begin
      fails++;
      $display("FAIL R8: after release done=%0b strobe=%0b status=%0d expected 0 0 0", done, eng_strobe, status);
    end

    send(32'sd0,         7'h67, 1'b0, 1'b0, 0, 1'b0); // R5 ok
    send(32'sd8161512,   7'h67, 1'b0, 1'b0, 0, 1'b0); // R1 upper bound accepted
    send(-32'sd8161512,  7'h67, 1'b0, 1'b1, 0, 1'b0); // R1 lower bound, R5 nack
    send(32'sd8161513,   7'h67, 1'b0, 1'b0, 0, 1'b0); // R1 reject
    send(-32'sd8161513,  7'h67, 1'b0, 1'b0, 0, 1'b0); // R1 reject
    send(32'sh80000000,  7'h67, 1'b0, 1'b0, 0, 1'b0); // R1 most negative
    send(32'sd100,       7'h12, 1'b1, 1'b0, 0, 1'b0); // R2 bus owned
    send(32'sd9000000,   7'h12, 1'b1, 1'b0, 0, 1'b0); // R2 range precedence
    send(32'sd12345,     7'h12, 1'b0, 1'b0, 8, 1'b0); // R3 wait for idle
    send(-32'sd1,        7'h3c, 1'b0, 1'b1, 0, 1'b1); // R7 ignored request, R4 pattern
    send(32'sd5000,      7'h3c, 1'b0, 1'b0, 2, 1'b1); // R7 with busy hold
    send(-32'sd77,       7'h01, 1'b0, 1'b1, 3, 1'b0); // R3 + R5 nack

    repeat (10) @(negedge clk);
    checks++;
    if (res_q.size() != 0 || wr_q.size() != 0) begin
      fails++;
      $display("FAIL R6: pending results=%0d writes=%0d expected 0 0", res_q.size(), wr_q.size());
    end
    checks++;
    if (done_seen != 12 || strobe_seen != 7) begin
      fails++;
      $display("FAIL R7: dones=%0d strobes=%0d expected 12 7", done_seen, strobe_seen);
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, finished=0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule